// File: doc/BRIEF.md
# T1-to-T2 Bit-Interleaving Multiplexer

This block builds one T2 serial bit stream out of four independently clocked T1 tributaries. Each tributary is presented through an external elastic buffer. The block sees the head bit of that buffer and its fill level, and it returns a read strobe whenever it takes a bit. One T2 bit leaves the block on every clock. A marker flags the first bit of every frame.

The output frame is 1176 bits long and is split into four subframes. Each subframe has six blocks, and each block is one overhead bit followed by 48 information bits. The information bits take one bit from each tributary in turn: tributary 1, 2, 3, 4, then 1 again. Tributaries 2 and 4 are inverted on the way out. The overhead slots carry four kinds of bit:
- an alarm bit (X) in the first subframe;
- fixed alignment bits (M and F);
- a triplet of justification-control bits (C1, C2, C3).

The C triplet announces whether the stuff slot of that subframe carries a dummy bit. Subframe n gives tributary n its stuffing chance. A tributary whose buffer runs low gets a stuff. A loopback request flips the third control bit.

A small sequencer has two named states:
- `S_OVERHEAD`: one overhead slot.
- `S_PAYLOAD`: 48 information slots.

There are two transitions:
- `S_OVERHEAD -> S_PAYLOAD` is always taken after one slot.
- `S_PAYLOAD -> S_OVERHEAD` is taken after the 48th information slot.

Block, subframe and frame counters advance on the second transition. Reset places the sequencer in `S_OVERHEAD` at block 0 of subframe 0.

Top module: `t2_interleave_mux`

## Requirements
- R1: A frame is 4 subframes × 6 blocks × 49 bits = 1176 bits. `frame_start` is 1 exactly on the first bit of each frame and 0 on all other bits.
- R2: Within a block, overhead bit index 0 is followed by 48 information bits taken from tributaries 1,2,3,4 in rotation, 12 each. `trib_pop[i]` is high, one-hot, in the cycle where the bit of tributary i+1 is taken from `trib_bit[i]`. That bit appears on `t2_data` one clock later.
- R3: Bits of tributaries 2 and 4 (`trib_bit[1]`, `trib_bit[3]`) are inverted on `t2_data`. Bits of tributaries 1 and 3 are sent unchanged.
- R4: The overhead bit of block 0 is the M bit in subframes 2, 3 and 4, with values 0, 1, 1. In every subframe the overhead bit of block 2 (F1) is 0 and the overhead bit of block 5 (F2) is 1.
- R5: In subframe n, the overhead bits of blocks 1, 3 and 4 (C1, C2, C3) are all 1 when tributary n must be stuffed and all 0 otherwise. Tributary n must be stuffed when its fill `trib_fill[(n-1)*FILL_W +: FILL_W]` is strictly less than `STUFF_THRESH`. The fill is sampled in the cycle that forms the first overhead bit of subframe n.
- R6: When stuffing, the stuff slot carries a 0 instead of data and tributary n is not popped. The stuff slot is the nth information bit of block 5 of subframe n. Without stuffing, that slot carries tributary n data as usual.
- R7: The overhead bit of block 0 in subframe 1 is the X bit. It is 0 when `remote_alarm` is 1 and 1 when `remote_alarm` is 0, sampled as that bit is formed.
- R8: When `loop_req[n-1]` is 1 at the start of subframe n, C3 of that subframe is the inverse of C1 and C2.
- R9: While `rst_n` is low, `t2_data`, `frame_start` and `trib_pop` are all 0. The first clock edge after release sends the X bit of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T2 bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trib_bit | input | 4 | Head bit of each tributary elastic buffer (bit 0 = tributary 1) |
| trib_fill | input | 4*FILL_W | Fill level of each elastic buffer, tributary 1 in the low field |
| loop_req | input | 4 | Loopback request per tributary |
| remote_alarm | input | 1 | Local T2 receive framer out of sync |
| t2_data | output | 1 | T2 serial data |
| frame_start | output | 1 | High on the first bit of each frame |
| trib_pop | output | 4 | Read strobe to each elastic buffer |

## Verification
The assertions check four properties on every cycle:
- the read strobes are one-hot;
- the read strobes rotate between tributaries on consecutive information bits;
- frame markers are exactly 1176 bits apart;
- the X bit matches the alarm input.

Only the bench scenarios can show the bit values that depend on a subframe's stuffing decision. These are the fill comparison at and just below the threshold, the dummy bit in the right slot, the skipped read, and the C3 inversion under loopback. The bench also carries tributary data across stuffed and unstuffed subframes.

// File: rtl/t2mux_pkg.sv
package t2mux_pkg;
    parameter int NUM_TRIB  = 4;
    parameter int SUBFRAMES = 4;
    parameter int BLOCKS    = 6;
    parameter int INFO_BITS = 48;
    parameter int SF_W      = $clog2(SUBFRAMES);
    parameter int BLK_W     = $clog2(BLOCKS);
    parameter int INFO_W    = $clog2(INFO_BITS);
    parameter int FRAME_BITS = SUBFRAMES * BLOCKS * (INFO_BITS + 1);
    parameter logic [NUM_TRIB-1:0] INV_MASK = 4'b1010;

    typedef enum logic [0:0] {
        S_OVERHEAD = 1'b0,
        S_PAYLOAD  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/t2mux_frame_seq.sv
module t2mux_frame_seq
    import t2mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output slot_state_e       state,
    output logic [SF_W-1:0]   sf_idx,
    output logic [BLK_W-1:0]  blk_idx,
    output logic [INFO_W-1:0] info_idx,
    output logic              sf_start
);
    slot_state_e state_nx;
    logic last_info;
    logic last_blk;

    assign last_info = (info_idx == INFO_W'(INFO_BITS - 1));
    assign last_blk  = (blk_idx == BLK_W'(BLOCKS - 1));
    assign sf_start  = (state == S_OVERHEAD) && (blk_idx == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_OVERHEAD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_OVERHEAD: state_nx = S_PAYLOAD;
            S_PAYLOAD:  state_nx = last_info ? S_OVERHEAD : S_PAYLOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info_idx <= '0;
            blk_idx  <= '0;
            sf_idx   <= '0;
        end else if (state == S_PAYLOAD) begin
            if (last_info) begin
                info_idx <= '0;
                if (last_blk) begin
                    blk_idx <= '0;
                    sf_idx  <= (sf_idx == SF_W'(SUBFRAMES - 1)) ? '0 : sf_idx + 1'b1;
                end else begin
                    blk_idx <= blk_idx + 1'b1;
                end
            end else begin
                info_idx <= info_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/t2mux_stuff_ctl.sv
module t2mux_stuff_ctl
    import t2mux_pkg::*;
#(
    parameter int FILL_W       = 4,
    parameter int STUFF_THRESH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sf_start,
    input  logic [SF_W-1:0]            sf_idx,
    input  logic [NUM_TRIB*FILL_W-1:0] trib_fill,
    input  logic [NUM_TRIB-1:0]        loop_req,
    output logic                       stuff_q,
    output logic                       loop_q
);
    logic [NUM_TRIB-1:0] fill_low;

    for (genvar i = 0; i < NUM_TRIB; i++) begin : g_low
        assign fill_low[i] = (trib_fill[i*FILL_W +: FILL_W] < FILL_W'(STUFF_THRESH));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stuff_q <= 1'b0;
            loop_q  <= 1'b0;
        end else if (sf_start) begin
            stuff_q <= fill_low[sf_idx];
            loop_q  <= loop_req[sf_idx];
        end
    end
endmodule

// File: rtl/t2mux_bit_sel.sv
module t2mux_bit_sel
    import t2mux_pkg::*;
(
    input  slot_state_e         state,
    input  logic [SF_W-1:0]     sf_idx,
    input  logic [BLK_W-1:0]    blk_idx,
    input  logic [INFO_W-1:0]   info_idx,
    input  logic                stuff_q,
    input  logic                loop_q,
    input  logic                remote_alarm,
    input  logic [NUM_TRIB-1:0] trib_bit,
    output logic                bit_nx,
    output logic                fs_nx,
    output logic [NUM_TRIB-1:0] pop
);
    logic [1:0] lane;
    logic       stuff_slot;

    assign lane       = info_idx[1:0];
    assign stuff_slot = stuff_q && (blk_idx == BLK_W'(BLOCKS - 1))
                        && (info_idx == INFO_W'(sf_idx));

    always_comb begin
        bit_nx = 1'b0;
        fs_nx  = 1'b0;
        pop    = '0;
        unique case (state)
            S_OVERHEAD: begin
                fs_nx = (blk_idx == '0) && (sf_idx == '0);
                case (blk_idx)
                    3'd0:    bit_nx = (sf_idx == '0) ? ~remote_alarm : (sf_idx != SF_W'(1));
                    3'd1:    bit_nx = stuff_q;
                    3'd2:    bit_nx = 1'b0;
                    3'd3:    bit_nx = stuff_q;
                    3'd4:    bit_nx = stuff_q ^ loop_q;
                    3'd5:    bit_nx = 1'b1;
                    default: bit_nx = 1'b0;
                endcase
            end
            S_PAYLOAD: begin
                if (!stuff_slot) begin
                    bit_nx    = trib_bit[lane] ^ INV_MASK[lane];
                    pop[lane] = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/t2_interleave_mux.sv
module t2_interleave_mux
    import t2mux_pkg::*;
#(
    parameter int FILL_W       = 4,
    parameter int STUFF_THRESH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_TRIB-1:0]        trib_bit,
    input  logic [NUM_TRIB*FILL_W-1:0] trib_fill,
    input  logic [NUM_TRIB-1:0]        loop_req,
    input  logic                       remote_alarm,
    output logic                       t2_data,
    output logic                       frame_start,
    output logic [NUM_TRIB-1:0]        trib_pop
);
    slot_state_e       state;
    logic [SF_W-1:0]   sf_idx;
    logic [BLK_W-1:0]  blk_idx;
    logic [INFO_W-1:0] info_idx;
    logic              sf_start;
    logic              stuff_q;
    logic              loop_q;
    logic              bit_nx;
    logic              fs_nx;

    t2mux_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .sf_idx   (sf_idx),
        .blk_idx  (blk_idx),
        .info_idx (info_idx),
        .sf_start (sf_start)
    );

    t2mux_stuff_ctl #(.FILL_W(FILL_W), .STUFF_THRESH(STUFF_THRESH)) u_stuff (
        .clk       (clk),
        .rst_n     (rst_n),
        .sf_start  (sf_start),
        .sf_idx    (sf_idx),
        .trib_fill (trib_fill),
        .loop_req  (loop_req),
        .stuff_q   (stuff_q),
        .loop_q    (loop_q)
    );

    t2mux_bit_sel u_sel (
        .state        (state),
        .sf_idx       (sf_idx),
        .blk_idx      (blk_idx),
        .info_idx     (info_idx),
        .stuff_q      (stuff_q),
        .loop_q       (loop_q),
        .remote_alarm (remote_alarm),
        .trib_bit     (trib_bit),
        .bit_nx       (bit_nx),
        .fs_nx        (fs_nx),
        .pop          (trib_pop)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t2_data     <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            t2_data     <= bit_nx;
            frame_start <= fs_nx;
        end
    end
endmodule

// File: rtl/t2mux_checker.sv
module t2mux_checker
    import t2mux_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_TRIB-1:0] trib_pop,
    input logic                t2_data,
    input logic                frame_start,
    input logic                remote_alarm
);
    localparam int CNT_W = $clog2(FRAME_BITS) + 1;
    logic [CNT_W-1:0] since_fs;
    logic             fs_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_fs <= '0;
            fs_seen  <= 1'b0;
        end else if (frame_start) begin
            since_fs <= '0;
            fs_seen  <= 1'b1;
        end else begin
            since_fs <= since_fs + 1'b1;
        end
    end

    AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trib_pop)); // R2

    AST_POP_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (trib_pop != '0 && $past(trib_pop) != '0) |->
        trib_pop == {$past(trib_pop[NUM_TRIB-2:0]), $past(trib_pop[NUM_TRIB-1])}); // R2

    AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && fs_seen) |-> since_fs == CNT_W'(FRAME_BITS - 1)); // R1

    AST_FRAME_NOT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        fs_seen |-> since_fs < CNT_W'(FRAME_BITS)); // R1

    AST_XBIT_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> t2_data == !$past(remote_alarm)); // R7

    AST_NO_POP_AT_OVH: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> $past(trib_pop) == '0); // R2
endmodule

bind t2_interleave_mux t2mux_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trib_pop     (trib_pop),
    .t2_data      (t2_data),
    .frame_start  (frame_start),
    .remote_alarm (remote_alarm)
);

// File: tb/tb_t2_interleave_mux.sv
module tb_t2_interleave_mux;
    localparam int FILL_W = 4;
    localparam int THRESH = 4;
    localparam int FRAME  = 1176;

    typedef struct {
        logic  fs;
        logic  d;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] trib_bit = '0;
    logic [4*FILL_W-1:0] trib_fill = '0;
    logic [3:0] loop_req = '0;
    logic remote_alarm = 1'b0;
    logic t2_data, frame_start;
    logic [3:0] trib_pop;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    exp_t q[$];
    int drv_idx[4];
    int exp_idx[4];
    logic [3:0] last_pop = '0;

    always #2.5 clk = ~clk;

    t2_interleave_mux #(.FILL_W(FILL_W), .STUFF_THRESH(THRESH)) dut (
        .clk(clk), .rst_n(rst_n), .trib_bit(trib_bit), .trib_fill(trib_fill),
        .loop_req(loop_req), .remote_alarm(remote_alarm),
        .t2_data(t2_data), .frame_start(frame_start), .trib_pop(trib_pop)
    );

    function automatic logic pat(int t, int k);
        int v;
        v = (k * 40503 + t * 977) ^ (k >> 3);
        return v[5] ^ v[2] ^ v[9];
    endfunction

    // tributary buffer model: advance on each strobe seen in the previous cycle
    initial begin
        for (int i = 0; i < 4; i++) drv_idx[i] = 0;
        forever begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                if (last_pop[i]) drv_idx[i]++;
                trib_bit[i] = pat(i, drv_idx[i]);
            end
            last_pop = trib_pop;
        end
    end

    // driver: pushes one frame of expected bits for the current settings
    task automatic push_frame();
        for (int sf = 0; sf < 4; sf++) begin
            logic stf, lp;
            stf = (trib_fill[sf*FILL_W +: FILL_W] < THRESH);
            lp  = loop_req[sf];
            for (int blk = 0; blk < 6; blk++) begin
                exp_t e;
                e.fs = (sf == 0 && blk == 0);
                case (blk)
                    0: begin
                        if (sf == 0) begin e.d = !remote_alarm; e.tag = "R7"; end
                        else begin e.d = (sf != 1); e.tag = "R4"; end
                    end
                    1, 3: begin e.d = stf; e.tag = "R5"; end
                    2: begin e.d = 1'b0; e.tag = "R4"; end
                    4: begin e.d = lp ? !stf : stf; e.tag = lp ? "R8" : "R5"; end
                    default: begin e.d = 1'b1; e.tag = "R4"; end
                endcase
                q.push_back(e);
                for (int d = 0; d < 48; d++) begin
                    int t;
                    exp_t x;
                    t = d % 4;
                    x.fs = 1'b0;
                    if (blk == 5 && d == sf && stf) begin
                        x.d = 1'b0; x.tag = "R6";
                    end else begin
                        x.d = pat(t, exp_idx[t]) ^ (t % 2 == 1);
                        x.tag = (t % 2 == 1) ? "R3" : "R2";
                        if (blk == 5 && d == sf) x.tag = "R6";
                        exp_idx[t]++;
                    end
                    q.push_back(x);
                end
            end
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // monitor
    initial begin
        exp_t e;
        wait (rst_n === 1'b1);
        @(posedge clk);
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                compared++;
                if (t2_data !== e.d) begin
                    mismatched++;
                    $display("FAIL %s: t2_data=%0b expected %0b", e.tag, t2_data, e.d);
                end else if (frame_start !== e.fs) begin
                    mismatched++;
                    $display("FAIL R1: frame_start=%0b expected %0b", frame_start, e.fs);
                end
            end
        end
    end

    task automatic set_fill(int f1, int f2, int f3, int f4);
        trib_fill = {FILL_W'(f4), FILL_W'(f3), FILL_W'(f2), FILL_W'(f1)};
    endtask

    initial begin
        for (int i = 0; i < 4; i++) exp_idx[i] = 0;
        // scenario A: no stuffing, no alarm
        set_fill(8, 8, 8, 8);
        loop_req = 4'b0000;
        remote_alarm = 1'b0;
        repeat (4) @(negedge clk);
        compared++;
        if (t2_data !== 1'b0 || frame_start !== 1'b0 || trib_pop !== 4'b0) begin
            mismatched++;
            $display("FAIL R9: reset outputs data=%0b fs=%0b pop=%b expected 0 0 0000",
                     t2_data, frame_start, trib_pop);
        end
        push_frame();
        rst_n = 1'b1;
        repeat (FRAME) @(negedge clk);
        // scenario B: stuff tributaries 1 and 3, alarm raised
        set_fill(2, 8, 0, 8);
        remote_alarm = 1'b1;
        push_frame();
        repeat (FRAME) @(negedge clk);
        // scenario C: all stuffed, loopback on tributaries 2 and 4
        set_fill(1, 1, 1, 1);
        remote_alarm = 1'b0;
        loop_req = 4'b1010;
        push_frame();
        repeat (FRAME) @(negedge clk);
        // scenario D: fill at threshold vs one below, loopback without stuff
        set_fill(THRESH, THRESH - 1, THRESH, THRESH - 1);
        loop_req = 4'b0001;
        push_frame();
        repeat (FRAME) @(negedge clk);
        // scenario E: maximum fill, alarm again, no loopback
        set_fill(15, 0, 15, 3);
        loop_req = 4'b0000;
        remote_alarm = 1'b1;
        push_frame();
        repeat (FRAME) @(negedge clk);
        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            mismatched++;
            $display("FAIL R1: %0d expected bits left, expected 0", q.size());
        end
        finish_run();
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL R1: watchdog expired, actual hung expected done");
        finish_run();
    end
endmodule